// File: doc/BRIEF.md
# Differential Clock Output Gating and Power-Down Sequencer

This block decides when each of four differential clock pairs and one single-ended reference clock may run. It sits between the PLL and the output drivers and runs on the PLL clock `clk`. It divides that clock by two to form the shared output phase, and it gates each pair with a per-pair run flag. A run flag changes only on the edge where the true output falls, so every high phase that is shown is a full one. A stopping output always finishes its current high phase.

A pair may run only when four things hold: the device has started, power-good is high, the PLL reports lock, and both of its enables are asserted. Its pin enable is active-low and its register enable is active-high. The power-good/power-down input (`pwr_good`), the lock input and the enable pins are asynchronous, so each passes through a two-flop synchroniser.

The first rising edge of power-good starts the device and captures the tri-level spread strap. The strap code is kept until reset. Later lows of power-good enter power-down and later highs leave it. The reference output is high-impedance until start. After start it is driven, and it is low during power-down unless a wake bit keeps it running. The spread code presented to the PLL comes from the strap, unless a software override bit selects a software code.

Top module: `clk_out_ctrl`

## Requirements
- R1: After reset and before the first power-good high, every `clk_p`/`clk_n` is 0, `ref_drive` is 0 (reference is high-impedance), `strap_rb` is 00, and `spread_code` shows 00 unless the software override is set.
- R2: On the first synchronised power-good high, the strap input `strap_ss` is captured. The mapping is 00 (tied low) to code 00 (spread off), 01 (mid level) to code 01 (-0.25%), and 10 or 11 (tied high) to code 11 (-0.5%). Strap changes after that capture are ignored until reset, including across power-down cycles.
- R3: While `lock_in` is 0, both outputs of every pair stay 0.
- R4: A pair runs only when it is started, power-good is high, lock is high, `en_pin_n[i]`=0 and `en_reg[i]`=1. While it runs, `clk_p[i]` toggles at half the `clk` rate and `clk_n[i]` is its complement. Otherwise both outputs are 0.
- R5: While power-good is low after start, every pair is low/low. A later power-good high resumes the enabled pairs without re-capturing the strap.
- R6: After start, `ref_drive` is 1. `ref_run` is 1 when `ref_en_reg`=1 and either power-good is high or `ref_wake`=1; otherwise `ref_run` is 0.
- R7: After a change on `en_pin_n[i]`, pair i starts or stops within 4 `clk` cycles (2 output clocks).
- R8: A run flag changes only on the edge where the output phase goes low, so `clk_p` never shows a shortened high phase.
- R9: With `ss_sw_ovr`=1, `spread_code` equals `ss_sw_code` (any value, including the reserved 10). With `ss_sw_ovr`=0, `spread_code` equals the captured strap code. `strap_rb` always shows the captured strap code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PLL output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Power-good (high) / power-down (low), asynchronous |
| lock_in | input | 1 | PLL lock indication, asynchronous |
| en_pin_n | input | 4 | Active-low per-pair enable pins, asynchronous |
| en_reg | input | 4 | Per-pair register enable bits |
| strap_ss | input | 2 | Tri-level spread strap: 00 low, 01 mid, 1x high |
| ss_sw_ovr | input | 1 | Software spread override enable |
| ss_sw_code | input | 2 | Software spread code |
| ref_wake | input | 1 | Keep reference running in power-down |
| ref_en_reg | input | 1 | Reference output register enable |
| clk_p | output | 4 | True outputs of the differential pairs |
| clk_n | output | 4 | Complement outputs of the differential pairs |
| ref_drive | output | 1 | Reference driver enabled (0 = high-impedance) |
| ref_run | output | 1 | Reference clock running (0 = driven low when driven) |
| spread_code | output | 2 | Spread code selected for the PLL |
| strap_rb | output | 2 | Captured strap code read-back |

## Verification
The gating is exercised with several patterns. Lock is held low while every enable is asserted, which separates the lock hold from the enable terms. Single pins are cleared while the other pairs keep running, which shows that the pin term is per-pair and meets the latency bound. Single register bits are cleared, which separates the register term from the pin term. Power-good is dropped with the wake bit clear and then set, which separates pair shutdown from the reference policy. Across resets the strap is started at each level and changed after start, to show both the mapping and the one-time capture. Finally the software override is toggled through several codes, including the reserved one, to confirm that it steers only the selected code and never the read-back.

// File: rtl/clk_out_ctrl_pkg.sv
package clk_out_ctrl_pkg;

  typedef enum logic [1:0] {
    SS_OFF  = 2'b00,
    SS_HALF = 2'b01,
    SS_RSVD = 2'b10,
    SS_FULL = 2'b11
  } ss_code_e;

  // Tri-level strap decode: 00 low, 01 mid, 1x high
  function automatic ss_code_e strap_to_code(input logic [1:0] lvl);
    if (lvl[1])      return SS_FULL;
    else if (lvl[0]) return SS_HALF;
    else             return SS_OFF;
  endfunction

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/strap_seq.sv
module strap_seq
  import clk_out_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pg_s,
  input  logic [1:0] strap_ss,
  input  logic       ss_sw_ovr,
  input  logic [1:0] ss_sw_code,
  output logic       started,
  output logic [1:0] spread_code,
  output logic [1:0] strap_rb
);
  ss_code_e strap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      strap_q <= SS_OFF;
    end else if (pg_s && !started) begin
      started <= 1'b1;
      strap_q <= strap_to_code(strap_ss);
    end
  end

  assign strap_rb    = strap_q;
  assign spread_code = ss_sw_ovr ? ss_sw_code : strap_q;

  // R2: once captured, the strap code never moves
  a_r2_strap_held: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(started)) |-> $stable(strap_q));

  // R2: the code 10 can never come from the strap
  a_r2_no_reserved_strap: assert property (@(posedge clk) disable iff (!rst_n)
    strap_q != SS_RSVD);
endmodule

// File: rtl/out_chan_gate.sv
module out_chan_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic phase,
  input  logic pg_ok,
  input  logic lock_ok,
  input  logic pin_en_n,
  input  logic reg_en,
  output logic out_p,
  output logic out_n
);
  logic want;
  logic run;
  logic [1:0] lag_cnt;

  assign want = pg_ok && lock_ok && !pin_en_n && reg_en;

  // Run flag updates only on the edge that ends the high phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run <= 1'b0;
    else if (phase) run <= want;
  end

  assign out_p = phase  & run;
  assign out_n = ~phase & run;

  // Cycles the request has been pending
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             lag_cnt <= '0;
    else if (want != run)   lag_cnt <= (lag_cnt == 2'd3) ? lag_cnt : lag_cnt + 2'd1;
    else                    lag_cnt <= '0;
  end

  // R8: the run flag changes only as the phase enters its low half
  a_r8_switch_in_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (run != $past(run)) |-> !phase);

  // R7: a request is honoured within two cycles of being seen
  a_r7_apply_latency: assert property (@(posedge clk) disable iff (!rst_n)
    lag_cnt != 2'd3);

  // R3: an output only starts while lock is reported
  a_r3_start_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(lock_ok));

  // R4/R5: an output only starts with power good and both enables
  a_r4_start_needs_enables: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> ($past(pg_ok) && !$past(pin_en_n) && $past(reg_en)));

  // R4: a pair never drives both legs high
  a_r4_legs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_p && out_n));
endmodule

// File: rtl/ref_gate_ctrl.sv
module ref_gate_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic started,
  input  logic pg_s,
  input  logic ref_wake,
  input  logic ref_en_reg,
  output logic ref_drive,
  output logic ref_run
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_drive <= 1'b0;
      ref_run   <= 1'b0;
    end else begin
      ref_drive <= started;
      ref_run   <= started && ref_en_reg && (pg_s || ref_wake);
    end
  end

  // R1: high-impedance until the device has started
  a_r1_hiz_before_start: assert property (@(posedge clk) disable iff (!rst_n)
    !started |=> !ref_drive);

  // R6: a running reference is always driven
  a_r6_run_implies_drive: assert property (@(posedge clk) disable iff (!rst_n)
    ref_run |-> ref_drive);

  // R6: in power-down without wake the reference stops
  a_r6_pd_stops_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (!pg_s && !ref_wake) |=> !ref_run);
endmodule

// File: rtl/clk_out_ctrl.sv
module clk_out_ctrl
  import clk_out_ctrl_pkg::*;
#(
  parameter int N_OUT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_good,
  input  logic             lock_in,
  input  logic [N_OUT-1:0] en_pin_n,
  input  logic [N_OUT-1:0] en_reg,
  input  logic [1:0]       strap_ss,
  input  logic             ss_sw_ovr,
  input  logic [1:0]       ss_sw_code,
  input  logic             ref_wake,
  input  logic             ref_en_reg,
  output logic [N_OUT-1:0] clk_p,
  output logic [N_OUT-1:0] clk_n,
  output logic             ref_drive,
  output logic             ref_run,
  output logic [1:0]       spread_code,
  output logic [1:0]       strap_rb
);
  localparam int SYNC_W = N_OUT + 2;

  logic [SYNC_W-1:0] async_in, sync_out;
  logic [N_OUT-1:0]  pin_s;
  logic              pg_s, lock_s, started, phase;

  // Async pins reset to "pins asserted" is harmless: gating waits for start
  assign async_in = {pwr_good, lock_in, en_pin_n};

  bit_sync #(.W(SYNC_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (async_in),
    .q     (sync_out)
  );

  assign pin_s  = sync_out[N_OUT-1:0];
  assign lock_s = sync_out[N_OUT];
  assign pg_s   = sync_out[N_OUT+1];

  strap_seq u_strap (
    .clk         (clk),
    .rst_n       (rst_n),
    .pg_s        (pg_s),
    .strap_ss    (strap_ss),
    .ss_sw_ovr   (ss_sw_ovr),
    .ss_sw_code  (ss_sw_code),
    .started     (started),
    .spread_code (spread_code),
    .strap_rb    (strap_rb)
  );

  // Shared divide-by-two output phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= 1'b0;
    else        phase <= ~phase;
  end

  for (genvar g = 0; g < N_OUT; g++) begin : g_chan
    out_chan_gate u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .phase    (phase),
      .pg_ok    (pg_s && started),
      .lock_ok  (lock_s),
      .pin_en_n (pin_s[g]),
      .reg_en   (en_reg[g]),
      .out_p    (clk_p[g]),
      .out_n    (clk_n[g])
    );
  end

  ref_gate_ctrl u_ref (
    .clk        (clk),
    .rst_n      (rst_n),
    .started    (started),
    .pg_s       (pg_s),
    .ref_wake   (ref_wake),
    .ref_en_reg (ref_en_reg),
    .ref_drive  (ref_drive),
    .ref_run    (ref_run)
  );

  // R1/R5: no pair runs before start
  a_r1_quiet_before_start: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> (clk_p == '0 && clk_n == '0));
endmodule

// File: tb/clk_out_ctrl_bench.sv
module clk_out_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_good = 1'b0, lock_in = 1'b0;
  logic [3:0] en_pin_n = 4'hF, en_reg = 4'hF;
  logic [1:0] strap_ss = 2'b00;
  logic       ss_sw_ovr = 1'b0;
  logic [1:0] ss_sw_code = 2'b00;
  logic       ref_wake = 1'b0, ref_en_reg = 1'b1;
  logic [3:0] clk_p, clk_n;
  logic       ref_drive, ref_run;
  logic [1:0] spread_code, strap_rb;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  clk_out_ctrl u_clk_out_ctrl (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .lock_in(lock_in),
    .en_pin_n(en_pin_n), .en_reg(en_reg), .strap_ss(strap_ss),
    .ss_sw_ovr(ss_sw_ovr), .ss_sw_code(ss_sw_code), .ref_wake(ref_wake),
    .ref_en_reg(ref_en_reg), .clk_p(clk_p), .clk_n(clk_n),
    .ref_drive(ref_drive), .ref_run(ref_run),
    .spread_code(spread_code), .strap_rb(strap_rb)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    @(negedge clk);
  endtask

  // Status of pair i over 4 cycles: 2 = running cleanly, 0 = held low/low, 9 = bad
  task automatic observe(input int i, output int st);
    int highs = 0;
    int bad = 0;
    int n_high = 0;
    for (int k = 0; k < 4; k++) begin
      if (clk_p[i]) highs++;
      if (clk_n[i]) n_high++;
      @(negedge clk);
    end
    if (highs == 2 && n_high == 2) st = 2;
    else if (highs == 0 && n_high == 0) st = 0;
    else st = 9;
    if (bad != 0) st = 9;
  endtask

  task automatic check_pairs(input string req, input logic [3:0] exp_run);
    int st;
    for (int i = 0; i < 4; i++) begin
      observe(i, st);
      check(req, st, exp_run[i] ? 2 : 0);
    end
  endtask

  task automatic do_reset(input logic [1:0] strap);
    rst_n = 1'b0; pwr_good = 1'b0; lock_in = 1'b0; strap_ss = strap;
    en_pin_n = 4'h0; en_reg = 4'hF; ss_sw_ovr = 1'b0; ref_wake = 1'b0; ref_en_reg = 1'b1;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
  endtask

  task automatic t_reset_state();
    do_reset(2'b01);
    wait_clk(4);
    check("R1 clk_p", clk_p, 0);
    check("R1 clk_n", clk_n, 0);
    check("R1 ref_drive", ref_drive, 0);
    check("R1 strap_rb", strap_rb, 0);
    check("R1 spread_code", spread_code, 0);
  endtask

  task automatic t_start_no_lock();
    pwr_good = 1'b1;
    wait_clk(6);
    check_pairs("R3 no lock", 4'h0);
    check("R6 ref_drive", ref_drive, 1);
    check("R6 ref_run", ref_run, 1);
    check("R2 mid strap", strap_rb, 1);
    check("R9 strap path", spread_code, 1);
  endtask

  task automatic t_lock_run();
    lock_in = 1'b1;
    wait_clk(6);
    check_pairs("R4 all running", 4'hF);
  endtask

  task automatic t_pin_latency();
    en_pin_n[2] = 1'b1;
    wait_clk(4);
    check_pairs("R7 pin stop", 4'b1011);
    en_pin_n[2] = 1'b0;
    wait_clk(4);
    check_pairs("R7 pin start", 4'hF);
  endtask

  task automatic t_reg_disable();
    en_reg[0] = 1'b0;
    wait_clk(4);
    check_pairs("R4 reg bit off", 4'b1110);
    en_reg[0] = 1'b1;
    en_pin_n[3] = 1'b1;
    wait_clk(4);
    check_pairs("R4 pin off", 4'b0111);
    en_pin_n[3] = 1'b0;
    wait_clk(4);
  endtask

  task automatic t_power_down();
    pwr_good = 1'b0;
    wait_clk(6);
    check_pairs("R5 power-down", 4'h0);
    check("R6 pd ref low", ref_run, 0);
    check("R6 pd ref driven", ref_drive, 1);
    strap_ss = 2'b10;
    pwr_good = 1'b1;
    wait_clk(6);
    check_pairs("R5 resume", 4'hF);
    check("R2 strap ignored after start", strap_rb, 1);
  endtask

  task automatic t_wake();
    ref_wake = 1'b1;
    pwr_good = 1'b0;
    wait_clk(5);
    check("R6 wake keeps ref", ref_run, 1);
    ref_en_reg = 1'b0;
    wait_clk(2);
    check("R6 ref reg off", ref_run, 0);
    ref_en_reg = 1'b1;
    ref_wake = 1'b0;
    pwr_good = 1'b1;
    wait_clk(5);
    check("R6 ref back", ref_run, 1);
  endtask

  task automatic t_sw_override();
    ss_sw_ovr = 1'b1; ss_sw_code = 2'b11;
    wait_clk(1);
    check("R9 sw code 11", spread_code, 3);
    check("R9 readback kept", strap_rb, 1);
    ss_sw_code = 2'b10;
    wait_clk(1);
    check("R9 sw reserved", spread_code, 2);
    ss_sw_ovr = 1'b0;
    wait_clk(1);
    check("R9 strap again", spread_code, 1);
  endtask

  task automatic t_strap_levels();
    do_reset(2'b10);
    pwr_good = 1'b1; wait_clk(5);
    check("R2 high strap", strap_rb, 3);
    do_reset(2'b11);
    pwr_good = 1'b1; wait_clk(5);
    check("R2 high strap alt", strap_rb, 3);
    do_reset(2'b00);
    pwr_good = 1'b1; wait_clk(5);
    check("R2 low strap", strap_rb, 0);
    check("R2 low spread", spread_code, 0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_start_no_lock();
    t_lock_run();
    t_pin_latency();
    t_reg_disable();
    t_power_down();
    t_wake();
    t_sw_override();
    t_strap_levels();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule